// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Condition Flags

This block is the purely combinational arithmetic and logic stage of a small 8-bit processor datapath. In one evaluation it turns an accumulator value, a second operand and the current flag byte into a result byte, a destination write strobe and a new flag byte. It has no clock, no state and no reset. Whatever surrounds it fetches the operands, registers the result and stores the flags.

A 3-bit class code picks the kind of operation. Class 0 is the accumulator group, and in that class a second 3-bit field picks one of eight two-operand operations. This field is the same field that bits 5:3 of the register-to-accumulator opcodes carry. The remaining classes are:

- increment and decrement of the second operand,
- negate of the accumulator,
- set-carry,
- complement-carry,
- decimal adjust of the accumulator,
- an idle code that changes nothing.

Flag handling depends on the class. Increment and decrement keep the carry. Compare computes flags but never writes. Flag bit 2 holds parity after logical operations and overflow after arithmetic ones.

Top module: `alu8_core`

## Requirements
- R1: With `op_class`=0, `acc_sel` chooses the operation: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 AND, 5 XOR, 6 OR, 7 compare. The second operand is `b_in` and the carry input is `f_in[0]`. The flag byte layout is S=bit 7, Z=bit 6, H=bit 4, P/V=bit 2, N=bit 1, C=bit 0.
- R2: Add and add-with-carry write `a_in+b_in(+C)` modulo 256 and assert `wr_en`. They set S from bit 7 of the result and Z when the result is zero. H is the carry out of bit 3. V is set when both operands have the same sign and the result's sign differs. N is 0, and C is the carry out of bit 7.
- R3: Subtract and subtract-with-borrow write `a_in-b_in(-C)` modulo 256. They set S and Z from the result. H is the borrow from bit 4. V is set when the operand signs differ and the result's sign differs from `a_in`'s. C is the borrow out, and N is 1.
- R4: Compare sets flags exactly as subtract does. It holds `wr_en` at 0 and presents `res` equal to `a_in`.
- R5: AND, XOR and OR write the bitwise result. S and Z come from the result, and P/V is 1 when the result has an even number of ones. N and C are cleared. H is 1 for AND and 0 for XOR and OR.
- R6: Class 1 (increment) and class 2 (decrement) write `b_in±1` modulo 256. H is the carry or borrow at the nibble boundary. V is set on 0x7F→0x80 for increment and on 0x80→0x7F for decrement. N is 0 for increment and 1 for decrement, and C is copied unchanged from `f_in`.
- R7: Class 3 (negate) writes `0-a_in`. N=1, and C is set when `a_in` is nonzero. V is set only for `a_in`=0x80. H is the borrow from bit 4, and S and Z come from the result.
- R8: Class 4 (set-carry) forces C=1 and clears H and N. Class 5 (complement-carry) inverts C, clears N and puts the old C into H. For both classes S, Z and P/V are kept, `wr_en` is 0 and `res` equals `a_in`.
- R9: Class 6 (decimal adjust) builds a correction from two parts. It adds 0x06 when H=1 or the low nibble of `a_in` exceeds 9, and 0x60 when C=1 or `a_in` exceeds 0x99. The correction is added when N=0 and subtracted when N=1. C is set when the 0x60 part applies. H is set as follows:
  - when N=0, it is set if the low nibble exceeded 9;
  - when N=1, it is set if H was set and the low nibble was below 6.

  N is kept, and S, Z and P (even parity) come from the adjusted value.
- R10: Class 7 changes nothing. `wr_en` is 0, `res` equals `a_in`, and the defined flag bits equal those of `f_in`.
- R11: Flag output bits 5 and 3 are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 8 | Accumulator operand |
| b_in | input | 8 | Second operand; also the target of increment and decrement |
| f_in | input | 8 | Current flag byte |
| op_class | input | 3 | Operation class |
| acc_sel | input | 3 | Accumulator operation when `op_class` is 0 |
| res | output | 8 | Result byte |
| wr_en | output | 1 | Result is to be written to the destination |
| f_out | output | 8 | Updated flag byte |

## Verification
The bench goes after the signed boundaries 0x7F/0x80. A wrong overflow rule would flag 0x7F+1 as no overflow, or flag 0xFF+1 as overflow. It also probes the nibble boundaries 0x0F and 0x10, where a half-carry taken from the wrong bit would miss. Carry-in handling is exercised by sweeping both carry values through every accumulator operation, which exposes an add that ignores carry or a subtract that borrows one too many. Decrement, increment, compare and the idle class are run with both carry values present, so a design that wrote the accumulator on compare, or clobbered carry on increment and decrement, would show a mismatch. Decimal adjust is swept over every byte with all H/N/C combinations, which catches a wrong threshold (9 vs 10, 0x99 vs 0x9A) or a wrong subtract-mode half-carry.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int W  = 8;
    localparam int HW = W / 2;

    typedef enum logic [2:0] {
        CLS_ACC  = 3'd0,
        CLS_INC  = 3'd1,
        CLS_DEC  = 3'd2,
        CLS_NEG  = 3'd3,
        CLS_SCF  = 3'd4,
        CLS_CCF  = 3'd5,
        CLS_DAA  = 3'd6,
        CLS_NONE = 3'd7
    } alu_cls_e;

    typedef enum logic [2:0] {
        AOP_ADD = 3'd0,
        AOP_ADC = 3'd1,
        AOP_SUB = 3'd2,
        AOP_SBC = 3'd3,
        AOP_AND = 3'd4,
        AOP_XOR = 3'd5,
        AOP_OR  = 3'd6,
        AOP_CP  = 3'd7
    } acc_op_e;

    typedef enum logic [1:0] {
        LOG_AND = 2'd0,
        LOG_XOR = 2'd1,
        LOG_OR  = 2'd2
    } log_op_e;

    typedef struct packed {
        logic s;
        logic z;
        logic h;
        logic pv;
        logic n;
        logic c;
    } flags_t;

    localparam int FB_S  = 7;
    localparam int FB_Z  = 6;
    localparam int FB_H  = 4;
    localparam int FB_PV = 2;
    localparam int FB_N  = 1;
    localparam int FB_C  = 0;

    function automatic logic even_ones(input logic [W-1:0] v);
        return ~^v;
    endfunction

    function automatic flags_t unpack_flags(input logic [W-1:0] f);
        flags_t t;
        t.s  = f[FB_S];
        t.z  = f[FB_Z];
        t.h  = f[FB_H];
        t.pv = f[FB_PV];
        t.n  = f[FB_N];
        t.c  = f[FB_C];
        return t;
    endfunction

    function automatic logic [W-1:0] pack_flags(input flags_t t);
        logic [W-1:0] f;
        f        = '0;
        f[FB_S]  = t.s;
        f[FB_Z]  = t.z;
        f[FB_H]  = t.h;
        f[FB_PV] = t.pv;
        f[FB_N]  = t.n;
        f[FB_C]  = t.c;
        return f;
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
(
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         half,
    output logic         ovf,
    output logic         cout
);

    logic [W-1:0] y_eff;
    logic         c_eff;
    logic [W:0]   full;
    logic [HW:0]  low;

    always_comb begin
        y_eff = sub ? ~y : y;
        c_eff = sub ^ cin;
        full  = {1'b0, x} + {1'b0, y_eff} + {{W{1'b0}}, c_eff};
        low   = {1'b0, x[HW-1:0]} + {1'b0, y_eff[HW-1:0]} + {{HW{1'b0}}, c_eff};
        sum   = full[W-1:0];
        cout  = full[W] ^ sub;
        half  = low[HW] ^ sub;
        ovf   = (x[W-1] == y_eff[W-1]) && (sum[W-1] != x[W-1]);
    end

    always_comb begin
        if (!$isunknown({x, y, cin, sub})) begin
            // R3: equal operands with no borrow in leave zero, no borrow out
            a_r3_equal_operands: assert (!(sub && !cin && (x == y)) ||
                                         ((sum == '0) && !cout && !half));
        end
    end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
(
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  log_op_e      kind,
    output logic [W-1:0] r,
    output logic         half
);

    always_comb begin
        unique case (kind)
            LOG_AND: begin
                r    = x & y;
                half = 1'b1;
            end
            LOG_XOR: begin
                r    = x ^ y;
                half = 1'b0;
            end
            LOG_OR: begin
                r    = x | y;
                half = 1'b0;
            end
            default: begin
                r    = '0;
                half = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/alu8_daa.sv
module alu8_daa
    import alu8_pkg::*;
(
    input  logic [W-1:0] a,
    input  logic         n_in,
    input  logic         h_in,
    input  logic         c_in,
    output logic [W-1:0] r,
    output logic         h_out,
    output logic         c_out
);

    logic         lo_big;
    logic         hi_big;
    logic [W-1:0] corr;

    always_comb begin
        lo_big = (a[HW-1:0] > 4'd9);
        hi_big = (a > 8'h99);
        corr   = '0;
        if (h_in || lo_big) corr[HW-1:0] = 4'h6;
        if (c_in || hi_big) corr[W-1:HW] = 4'h6;
        r      = n_in ? (a - corr) : (a + corr);
        c_out  = c_in || hi_big;
        h_out  = n_in ? (h_in && (a[HW-1:0] < 4'd6)) : lo_big;
    end

    always_comb begin
        if (!$isunknown({a, n_in, h_in, c_in})) begin
            // R9: an incoming carry is never dropped by the adjust
            a_r9_carry_kept: assert (!c_in || c_out);
        end
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic [7:0] a_in,
    input  logic [7:0] b_in,
    input  logic [7:0] f_in,
    input  logic [2:0] op_class,
    input  logic [2:0] acc_sel,
    output logic [7:0] res,
    output logic       wr_en,
    output logic [7:0] f_out
);

    alu_cls_e     cls;
    acc_op_e      aop;
    flags_t       fi;
    flags_t       fo;

    logic [W-1:0] ad_x, ad_y, ad_sum;
    logic         ad_cin, ad_sub, ad_half, ad_ovf, ad_cout;

    log_op_e      lg_kind;
    logic [W-1:0] lg_r;
    logic         lg_half;

    logic [W-1:0] dj_r;
    logic         dj_h, dj_c;

    assign cls = alu_cls_e'(op_class);
    assign aop = acc_op_e'(acc_sel);
    assign fi  = unpack_flags(f_in);

    // operand steering for the shared adder
    always_comb begin
        ad_x   = a_in;
        ad_y   = b_in;
        ad_cin = 1'b0;
        ad_sub = 1'b0;
        unique case (cls)
            CLS_ACC: begin
                ad_sub = (aop == AOP_SUB) || (aop == AOP_SBC) || (aop == AOP_CP);
                ad_cin = ((aop == AOP_ADC) || (aop == AOP_SBC)) && fi.c;
            end
            CLS_INC: begin
                ad_x = b_in;
                ad_y = 8'd1;
            end
            CLS_DEC: begin
                ad_x   = b_in;
                ad_y   = 8'd1;
                ad_sub = 1'b1;
            end
            CLS_NEG: begin
                ad_x   = '0;
                ad_y   = a_in;
                ad_sub = 1'b1;
            end
            default: ;
        endcase
    end

    always_comb begin
        unique case (aop)
            AOP_XOR: lg_kind = LOG_XOR;
            AOP_OR:  lg_kind = LOG_OR;
            default: lg_kind = LOG_AND;
        endcase
    end

    alu8_addsub u_addsub (
        .x    (ad_x),
        .y    (ad_y),
        .cin  (ad_cin),
        .sub  (ad_sub),
        .sum  (ad_sum),
        .half (ad_half),
        .ovf  (ad_ovf),
        .cout (ad_cout)
    );

    alu8_logic u_logic (
        .x    (a_in),
        .y    (b_in),
        .kind (lg_kind),
        .r    (lg_r),
        .half (lg_half)
    );

    alu8_daa u_daa (
        .a     (a_in),
        .n_in  (fi.n),
        .h_in  (fi.h),
        .c_in  (fi.c),
        .r     (dj_r),
        .h_out (dj_h),
        .c_out (dj_c)
    );

    // result and flag selection
    always_comb begin
        res   = a_in;
        wr_en = 1'b0;
        fo    = fi;
        unique case (cls)
            CLS_ACC: begin
                unique case (aop)
                    AOP_AND, AOP_XOR, AOP_OR: begin
                        res   = lg_r;
                        wr_en = 1'b1;
                        fo.s  = lg_r[W-1];
                        fo.z  = (lg_r == '0);
                        fo.h  = lg_half;
                        fo.pv = even_ones(lg_r);
                        fo.n  = 1'b0;
                        fo.c  = 1'b0;
                    end
                    default: begin
                        res   = (aop == AOP_CP) ? a_in : ad_sum;
                        wr_en = (aop != AOP_CP);
                        fo.s  = ad_sum[W-1];
                        fo.z  = (ad_sum == '0);
                        fo.h  = ad_half;
                        fo.pv = ad_ovf;
                        fo.n  = ad_sub;
                        fo.c  = ad_cout;
                    end
                endcase
            end
            CLS_INC, CLS_DEC, CLS_NEG: begin
                res   = ad_sum;
                wr_en = 1'b1;
                fo.s  = ad_sum[W-1];
                fo.z  = (ad_sum == '0);
                fo.h  = ad_half;
                fo.pv = ad_ovf;
                fo.n  = ad_sub;
                if (cls == CLS_NEG) fo.c = ad_cout;
            end
            CLS_SCF: begin
                fo.c = 1'b1;
                fo.h = 1'b0;
                fo.n = 1'b0;
            end
            CLS_CCF: begin
                fo.h = fi.c;
                fo.c = ~fi.c;
                fo.n = 1'b0;
            end
            CLS_DAA: begin
                res   = dj_r;
                wr_en = 1'b1;
                fo.s  = dj_r[W-1];
                fo.z  = (dj_r == '0);
                fo.h  = dj_h;
                fo.pv = even_ones(dj_r);
                fo.c  = dj_c;
            end
            default: ;
        endcase
    end

    assign f_out = pack_flags(fo);

    always_comb begin
        if (!$isunknown({a_in, b_in, f_in, op_class, acc_sel})) begin
            // R4: compare never writes and leaves the accumulator visible
            a_r4_cp_no_write: assert (!((cls == CLS_ACC) && (aop == AOP_CP)) ||
                                      (!wr_en && (res == a_in)));
            // R6: increment and decrement keep the carry
            a_r6_carry_kept: assert (!((cls == CLS_INC) || (cls == CLS_DEC)) ||
                                     (f_out[FB_C] == f_in[FB_C]));
            // R5: logical operations report parity and clear N and C
            a_r5_logic_parity: assert (!((cls == CLS_ACC) && (acc_sel[2] == 1'b1) &&
                                         (aop != AOP_CP)) ||
                                       ((f_out[FB_PV] == ~^res) && !f_out[FB_C] &&
                                        !f_out[FB_N]));
            // R11: unused flag bits read zero
            a_r11_unused_bits: assert ((f_out[5] == 1'b0) && (f_out[3] == 1'b0));
            // R10: idle class has no effect
            a_r10_idle: assert (!(cls == CLS_NONE) ||
                                (!wr_en && (res == a_in) && (f_out == (f_in & 8'hD7))));
        end
    end

endmodule

// File: tb/test_alu8_core.sv
module test_alu8_core;

    logic       clk;
    logic       rst_n;
    logic [7:0] a_in, b_in, f_in;
    logic [2:0] op_class, acc_sel;
    logic [7:0] res;
    logic       wr_en;
    logic [7:0] f_out;

    int n_vec;
    int n_bad;
    bit done;

    alu8_core i_alu8_core (
        .a_in     (a_in),
        .b_in     (b_in),
        .f_in     (f_in),
        .op_class (op_class),
        .acc_sel  (acc_sel),
        .res      (res),
        .wr_en    (wr_en),
        .f_out    (f_out)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    function automatic int par_even(input int v);
        int k;
        k = 0;
        for (int i = 0; i < 8; i++) k += (v >> i) & 1;
        return ((k % 2) == 0) ? 1 : 0;
    endfunction

    function automatic int sx(input int v);
        return (v >= 128) ? v - 256 : v;
    endfunction

    // returns {wr, res[7:0], flags[7:0]}
    function automatic logic [16:0] model(input int cls, input int sel,
                                          input int a, input int b, input int f);
        int r, s, z, h, p, n, c, wr, t, ci, sr, lo, corr;
        s = (f >> 7) & 1; z = (f >> 6) & 1; h = (f >> 4) & 1;
        p = (f >> 2) & 1; n = (f >> 1) & 1; c = f & 1;
        r = a; wr = 0;
        case (cls)
            0: begin
                ci = ((sel == 1) || (sel == 3)) ? c : 0;
                if (sel <= 1) begin
                    t = a + b + ci; r = t % 256; c = (t > 255);
                    h = ((a % 16) + (b % 16) + ci) > 15;
                    sr = sx(a) + sx(b) + ci; p = (sr > 127) || (sr < -128);
                    n = 0; wr = 1;
                end else if (sel == 2 || sel == 3 || sel == 7) begin
                    t = a - b - ci; r = (t + 256) % 256; c = (t < 0);
                    h = ((a % 16) - (b % 16) - ci) < 0;
                    sr = sx(a) - sx(b) - ci; p = (sr > 127) || (sr < -128);
                    n = 1; wr = (sel != 7);
                end else begin
                    if (sel == 4) r = a & b;
                    else if (sel == 5) r = a ^ b;
                    else r = a | b;
                    h = (sel == 4); p = par_even(r); n = 0; c = 0; wr = 1;
                end
                s = r / 128; z = (r == 0);
                if (sel == 7) r = a;
            end
            1, 2: begin
                if (cls == 1) begin
                    r = (b + 1) % 256; h = ((b % 16) == 15); p = (b == 127); n = 0;
                end else begin
                    r = (b + 255) % 256; h = ((b % 16) == 0); p = (b == 128); n = 1;
                end
                s = r / 128; z = (r == 0); wr = 1;
            end
            3: begin
                r = (256 - a) % 256; c = (a != 0); p = (a == 128);
                h = ((a % 16) != 0); n = 1; s = r / 128; z = (r == 0); wr = 1;
            end
            4: begin c = 1; h = 0; n = 0; end
            5: begin h = c; c = 1 - c; n = 0; end
            6: begin
                lo = a % 16; corr = 0; t = c;
                if (h == 1 || lo > 9) corr += 6;
                if (c == 1 || a > 153) begin corr += 96; t = 1; end
                r = (n == 1) ? (a - corr + 256) % 256 : (a + corr) % 256;
                h = (n == 1) ? ((h == 1) && (lo < 6)) : (lo > 9);
                c = t; s = r / 128; z = (r == 0); p = par_even(r); wr = 1;
            end
            default: ;
        endcase
        t = s * 128 + z * 64 + h * 16 + p * 4 + n * 2 + c;
        return {wr[0], r[7:0], t[7:0]};
    endfunction

    function automatic string tag_of(input int cls, input int sel);
        case (cls)
            0: begin
                if (sel <= 1) return "R2";
                if (sel <= 3) return "R3";
                if (sel == 7) return "R4";
                return "R5";
            end
            1, 2: return "R6";
            3: return "R7";
            4, 5: return "R8";
            6: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic apply(input int cls, input int sel, input int a, input int b,
                         input int f, input string force_tag);
        logic [16:0] exp;
        string tg;
        @(posedge clk);
        op_class = cls[2:0]; acc_sel = sel[2:0];
        a_in = a[7:0]; b_in = b[7:0]; f_in = f[7:0];
        exp = model(cls, sel, a, b, f);
        tg = (force_tag.len() > 0) ? force_tag : tag_of(cls, sel);
        @(negedge clk);
        n_vec++;
        if ({wr_en, res, f_out} !== exp) begin
            n_bad++;
            $display("FAIL %s cls=%0d sel=%0d a=%02h b=%02h f=%02h: got wr=%b res=%02h f=%02h, expected wr=%b res=%02h f=%02h",
                     tg, cls, sel, a, b, f, wr_en, res, f_out, exp[16], exp[15:8], exp[7:0]);
        end
        n_vec++;
        if ((f_out[5] | f_out[3]) !== 1'b0) begin
            n_bad++;
            $display("FAIL R11 unused flag bits: got %02h expected bits 5,3 zero", f_out);
        end
    endtask

    initial begin
        a_in = 0; b_in = 0; f_in = 0; op_class = 0; acc_sel = 0;
        n_vec = 0; n_bad = 0; done = 0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // idle-state vector: add of zeros gives zero with Z set (R2)
        apply(0, 0, 0, 0, 0, "R2");
        // R1: operation order across acc_sel
        for (int s = 0; s < 8; s++) apply(0, s, 8'h5A, 8'h3C, 8'h01, "R1");
        // signed and nibble boundaries
        apply(0, 0, 8'h7F, 8'h01, 0, "R2");
        apply(0, 0, 8'hFF, 8'h01, 0, "R2");
        apply(0, 1, 8'h0F, 8'h00, 1, "R2");
        apply(0, 2, 8'h80, 8'h01, 0, "R3");
        apply(0, 3, 8'h10, 8'h0F, 1, "R3");
        apply(0, 7, 8'h10, 8'h20, 0, "R4");
        apply(0, 7, 8'h42, 8'h42, 1, "R4");
        apply(1, 0, 0, 8'h7F, 8'h01, "R6");
        apply(2, 0, 0, 8'h80, 8'h00, "R6");
        apply(3, 0, 8'h80, 0, 0, "R7");
        apply(3, 0, 8'h00, 0, 1, "R7");
        apply(6, 0, 8'h9A, 0, 0, "R9");
        apply(6, 0, 8'h0F, 0, 8'h12, "R9");

        // sweep the accumulator group
        for (int s = 0; s < 8; s++)
            for (int ci = 0; ci < 2; ci++)
                for (int a = 0; a < 256; a += 13)
                    for (int b = 0; b < 256; b += 17)
                        apply(0, s, a, b, ci | 8'hA4, "");
        // increment, decrement, negate
        for (int v = 0; v < 256; v++) begin
            apply(1, 0, 8'h33, v, 0, "");
            apply(1, 0, 8'h33, v, 8'hFF, "");
            apply(2, 0, 8'h33, v, 0, "");
            apply(2, 0, 8'h33, v, 8'hFF, "");
            apply(3, 0, v, 8'h33, v & 8'hD7, "");
        end
        // carry control and idle class
        for (int f = 0; f < 256; f++) begin
            apply(4, 0, 8'h21, 8'h43, f, "");
            apply(5, 0, 8'h21, 8'h43, f, "");
        end
        for (int f = 0; f < 256; f += 17) apply(7, f % 8, f, 255 - f, f, "");
        // decimal adjust over all bytes and N/H/C combinations
        for (int a = 0; a < 256; a++)
            for (int k = 0; k < 8; k++)
                apply(6, 0, a, 0, ((k & 1) ? 8'h01 : 0) | ((k & 2) ? 8'h02 : 0) |
                                  ((k & 4) ? 8'h10 : 0), "");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got no completion, expected end of stimulus");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule